// File: doc/BRIEF.md
# Paired Set/Clear GPIO Controller

This block controls 32 general-purpose pins from a plain 32-bit register bus. The pins are grouped into two banks of 16. Address bit 7 picks the bank: the low bank holds pins 0 to 15 and the high bank holds pins 16 to 31. The two banks share one register layout. Each bank keeps six per-pin feature registers:

- output level
- drive enable
- open-drain mode
- pull-up
- pull-down
- input enable

Each bank also has a read-only input-level word, which is read through a two-flop synchronizer.

A feature register is never written as a plain value. The low half of the write word sets pins and the high half clears them. Software can therefore change one pin without a read-modify-write, and it cannot disturb a pin that another agent owns. Each bank computes its own pad controls from its registers. An open-drain pin only pulls low: when its output level is 1, the pin is released.

Top module: `gpio_pb_top`

## Requirements
- R1: After reset, every feature register is 0. `pad_out`, `pad_oe`, `pad_od`, `pad_pu` and `pad_pd` are all 0, and every read returns 0.
- R2: In a write, a 1 in bit n (n = 0..15) turns on the addressed feature for pin n of the selected bank, from the clock edge that takes the write.
- R3: In a write, a 1 in bit n+16 turns off the addressed feature for pin n of the selected bank.
- R4: A pin whose set bit and clear bit are both 0 keeps its state. With no write, no pad control output changes.
- R5: When the set bit and the clear bit of the same pin are both 1, the pin is cleared.
- R6: Address bit 7 selects the bank: 0 means pins 0..15 and 1 means pins 16..31. A write to one bank leaves the other bank unchanged.
- R7: Offsets within a bank: 0x00 output level, 0x04 drive enable, 0x08 open-drain, 0x18 pull-up, 0x1C pull-down, 0x20 input enable. A read returns the per-pin state in bits 15..0 and zeros in bits 31..16. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd` high.
- R8: Offset 0x30 returns the pad levels ANDed with input enable. The pad levels pass through two flops, so a read captured at the second edge after a pad change still shows the old level, and a read captured at the third edge shows the new level.
- R9: When open-drain is on for a pin, `pad_out` is 0 and `pad_oe` is the drive enable ANDed with the inverse of the output level. When open-drain is off, `pad_out` is the output level and `pad_oe` is the drive enable. `pad_od` mirrors the open-drain register.
- R10: A write to 0x30 or to any offset not listed in R7 changes nothing. A read of an unlisted offset returns 0.
- R11: `pad_pu` and `pad_pd` follow the pull-up and pull-down registers bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bit 7 selects the bank |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write word: set bits 15..0, clear bits 31..16 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read word, registered |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables |
| pad_od | output | 32 | Open-drain mode per pad |
| pad_pu | output | 32 | Pull-up enables |
| pad_pd | output | 32 | Pull-down enables |

## Verification
The pad control outputs change at the same clock edge that takes a write. The bench therefore drives each write at a falling edge and checks the pads at the next falling edge. Read data is registered, so the bench raises `bus_rd` for one cycle and samples `bus_rdata` half a cycle after that edge. For input read-back, the bench changes `pad_in` and then reads twice in a row. It expects the old level from the read captured at the second edge and the new level from the read captured at the third edge. In the random phase, the bench waits three cycles after every pad change before it trusts its model of the read-back word.

// File: rtl/gpio_pb_pkg.sv
`timescale 1ns/1ps
package gpio_pb_pkg;
   localparam int NUM_FEAT = 6;

   typedef enum logic [2:0] {
      FEAT_VAL = 3'd0,
      FEAT_OE  = 3'd1,
      FEAT_OD  = 3'd2,
      FEAT_PU  = 3'd3,
      FEAT_PD  = 3'd4,
      FEAT_IE  = 3'd5
   } feat_e;

   localparam int OFS_READBACK = 'h30;

   // Byte offset of each feature register within a bank
   function automatic int feat_offset(input int f);
      case (f)
         0:       feat_offset = 'h00;
         1:       feat_offset = 'h04;
         2:       feat_offset = 'h08;
         3:       feat_offset = 'h18;
         4:       feat_offset = 'h1C;
         default: feat_offset = 'h20;
      endcase
   endfunction
endpackage

// File: rtl/gpio_pb_decode.sv
`timescale 1ns/1ps
module gpio_pb_decode
   import gpio_pb_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                bank_hi,
   output logic [NUM_FEAT-1:0] feat_hit,
   output logic                rb_hit
);
   localparam int OFS_W = ADDR_W - 1;

   logic [OFS_W-1:0] ofs;

   always_comb begin
      bank_hi = addr[ADDR_W-1];
      ofs     = addr[OFS_W-1:0];
      for (int f = 0; f < NUM_FEAT; f++) begin
         feat_hit[f] = (ofs == OFS_W'(feat_offset(f)));
      end
      rb_hit = (ofs == OFS_W'(OFS_READBACK));
   end
endmodule

// File: rtl/gpio_pb_sync.sv
`timescale 1ns/1ps
module gpio_pb_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_pb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pb_bank.sv
`timescale 1ns/1ps
module gpio_pb_bank
   import gpio_pb_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [NUM_FEAT-1:0]            feat_hit,
   input  logic [PINS-1:0]                set_bits,
   input  logic [PINS-1:0]                clr_bits,
   input  logic [PINS-1:0]                pad_in,
   output logic [NUM_FEAT-1:0][PINS-1:0]  feat_q,
   output logic [PINS-1:0]                rb_q
);
   logic [PINS-1:0] pin_sync;

   genvar f;
   generate
      for (f = 0; f < NUM_FEAT; f++) begin : g_feat
         logic [PINS-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (wr_en && feat_hit[f]) begin
               // clear side applied last, so it wins on a conflict
               q <= (q | set_bits) & ~clr_bits;
            end
         end
         assign feat_q[f] = q;
      end
   endgenerate

   gpio_pb_sync #(
      .WIDTH (PINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pin_sync)
   );

   assign rb_q = pin_sync & feat_q[FEAT_IE];
endmodule

// File: rtl/gpio_pb_drive.sv
`timescale 1ns/1ps
module gpio_pb_drive #(
   parameter int PINS  = 16,
   parameter bit OD_EN = 1'b1
) (
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] drv_en,
   input  logic [PINS-1:0] od_mode,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_oe,
   output logic [PINS-1:0] pad_od
);
   genvar p;
   generate
      if (OD_EN) begin : g_od
         for (p = 0; p < PINS; p++) begin : g_pin
            always_comb begin
               if (od_mode[p]) begin
                  pad_out[p] = 1'b0;
                  pad_oe[p]  = drv_en[p] & ~lvl[p];
               end else begin
                  pad_out[p] = lvl[p];
                  pad_oe[p]  = drv_en[p];
               end
            end
         end
         assign pad_od = od_mode;
      end else begin : g_push_pull
         logic unused_od;
         assign unused_od = ^od_mode;
         assign pad_out   = lvl;
         assign pad_oe    = drv_en;
         assign pad_od    = '0;
      end
   endgenerate
endmodule

// File: rtl/gpio_pb_top.sv
`timescale 1ns/1ps
module gpio_pb_top
   import gpio_pb_pkg::*;
#(
   parameter int PINS_PER_BANK = 16,
   parameter int ADDR_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit OD_EN         = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic                         bus_wr,
   input  logic [2*PINS_PER_BANK-1:0]   bus_wdata,
   input  logic                         bus_rd,
   output logic [2*PINS_PER_BANK-1:0]   bus_rdata,
   input  logic [2*PINS_PER_BANK-1:0]   pad_in,
   output logic [2*PINS_PER_BANK-1:0]   pad_out,
   output logic [2*PINS_PER_BANK-1:0]   pad_oe,
   output logic [2*PINS_PER_BANK-1:0]   pad_od,
   output logic [2*PINS_PER_BANK-1:0]   pad_pu,
   output logic [2*PINS_PER_BANK-1:0]   pad_pd
);
   localparam int P      = PINS_PER_BANK;
   localparam int DATA_W = 2 * P;
   localparam int BANKS  = 2;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("gpio_pb_top: ADDR_W too small for the register layout");
      end
      if (P < 1 || P > 16) begin : g_bad_pins
         $error("gpio_pb_top: PINS_PER_BANK must be 1..16");
      end
   endgenerate

   logic                          bank_hi;
   logic [NUM_FEAT-1:0]           feat_hit;
   logic                          rb_hit;
   logic [NUM_FEAT-1:0][P-1:0]    bank_feat [BANKS];
   logic [P-1:0]                  bank_rb   [BANKS];
   logic [DATA_W-1:0]             rd_word;

   gpio_pb_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (bus_addr),
      .bank_hi (bank_hi),
      .feat_hit(feat_hit),
      .rb_hit  (rb_hit)
   );

   genvar b;
   generate
      for (b = 0; b < BANKS; b++) begin : g_bank
         logic wr_this;
         assign wr_this = bus_wr && (bank_hi == b[0]);

         gpio_pb_bank #(
            .PINS       (P),
            .SYNC_STAGES(SYNC_STAGES)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_this),
            .feat_hit(feat_hit),
            .set_bits(bus_wdata[P-1:0]),
            .clr_bits(bus_wdata[DATA_W-1:P]),
            .pad_in  (pad_in[b*P +: P]),
            .feat_q  (bank_feat[b]),
            .rb_q    (bank_rb[b])
         );

         gpio_pb_drive #(
            .PINS (P),
            .OD_EN(OD_EN)
         ) u_drive (
            .lvl    (bank_feat[b][FEAT_VAL]),
            .drv_en (bank_feat[b][FEAT_OE]),
            .od_mode(bank_feat[b][FEAT_OD]),
            .pad_out(pad_out[b*P +: P]),
            .pad_oe (pad_oe[b*P +: P]),
            .pad_od (pad_od[b*P +: P])
         );

         assign pad_pu[b*P +: P] = bank_feat[b][FEAT_PU];
         assign pad_pd[b*P +: P] = bank_feat[b][FEAT_PD];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int f = 0; f < NUM_FEAT; f++) begin
         if (feat_hit[f]) rd_word[P-1:0] = bank_feat[bank_hi][f];
      end
      if (rb_hit) rd_word[P-1:0] = bank_rb[bank_hi];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_word;
      end
   end
endmodule

// File: rtl/gpio_pb_checker.sv
`timescale 1ns/1ps
module gpio_pb_checker #(
   parameter int PINS   = 16,
   parameter int ADDR_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic [2*PINS-1:0]    bus_wdata,
   input logic                 bus_rd,
   input logic [2*PINS-1:0]    bus_rdata,
   input logic [2*PINS-1:0]    pad_out,
   input logic [2*PINS-1:0]    pad_oe,
   input logic [2*PINS-1:0]    pad_od,
   input logic [2*PINS-1:0]    pad_pu,
   input logic [2*PINS-1:0]    pad_pd
);
   localparam int OFS_W = ADDR_W - 1;

   logic wr_pu_lo;
   logic wr_dead;
   assign wr_pu_lo = bus_wr && (bus_addr == ADDR_W'('h18));
   assign wr_dead  = bus_wr && ((bus_addr[OFS_W-1:0] == OFS_W'('h30)) ||
                                (bus_addr[OFS_W-1:0] == OFS_W'('h40)));

   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pu_lo |=> ((($past(bus_wdata[PINS-1:0]) & ~$past(bus_wdata[2*PINS-1:PINS]))
                     & ~pad_pu[PINS-1:0]) == '0));

   assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pu_lo |=> ((pad_pu[PINS-1:0] & $past(bus_wdata[2*PINS-1:PINS])) == '0));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_od) &&
                   $stable(pad_pu) && $stable(pad_pd)));

   assert_bank_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1]) |=> ($stable(pad_out[PINS-1:0]) &&
         $stable(pad_oe[PINS-1:0]) && $stable(pad_pu[PINS-1:0]) &&
         $stable(pad_pd[PINS-1:0]) && $stable(pad_od[PINS-1:0])));

   assert_od_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_od & pad_out) == '0));

   assert_dead_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dead |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_od) &&
                   $stable(pad_pu) && $stable(pad_pd)));

   assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (bus_rdata[2*PINS-1:PINS] == '0));
endmodule

bind gpio_pb_top gpio_pb_checker #(
   .PINS  (PINS_PER_BANK),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .pad_od   (pad_od),
   .pad_pu   (pad_pu),
   .pad_pd   (pad_pd)
);

// File: tb/tb_gpio_pb_top.sv
`timescale 1ns/1ps
module tb_gpio_pb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] mreg [2][6];

   always #2.5 clk = ~clk;

   gpio_pb_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
      .pad_pu(pad_pu), .pad_pd(pad_pd)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int feat_of(input logic [6:0] o);
      case (o)
         7'h00: feat_of = 0;
         7'h04: feat_of = 1;
         7'h08: feat_of = 2;
         7'h18: feat_of = 3;
         7'h1C: feat_of = 4;
         7'h20: feat_of = 5;
         7'h30: feat_of = 6;
         default: feat_of = -1;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int f = feat_of(a[6:0]);
      int b = int'(a[7]);
      if (f >= 0 && f < 6) exp_read = {16'h0, mreg[b][f]};
      else if (f == 6)     exp_read = {16'h0, mreg[b][5] & pad_in[b*16 +: 16]};
      else                 exp_read = '0;
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      int f = feat_of(a[6:0]);
      int b = int'(a[7]);
      if (f >= 0 && f < 6) mreg[b][f] = (mreg[b][f] | d[15:0]) & ~d[31:16];
   endtask

   task automatic check_pads(input string req);
      logic [31:0] e_out, e_oe, e_od, e_pu, e_pd;
      for (int b = 0; b < 2; b++) begin
         e_out[b*16 +: 16] = mreg[b][0] & ~mreg[b][2];
         e_oe[b*16 +: 16]  = mreg[b][1] & ~(mreg[b][2] & mreg[b][0]);
         e_od[b*16 +: 16]  = mreg[b][2];
         e_pu[b*16 +: 16]  = mreg[b][3];
         e_pd[b*16 +: 16]  = mreg[b][4];
      end
      chk({req, " pad_out"}, pad_out, e_out);
      chk({req, " pad_oe"},  pad_oe,  e_oe);
      chk({req, " pad_od"},  pad_od,  e_od);
      chk({req, " pad_pu R11"}, pad_pu, e_pu);
      chk({req, " pad_pd R11"}, pad_pd, e_pd);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] r);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      r = bus_rdata;
   endtask

   task automatic read_chk(input string req, input logic [7:0] a);
      logic [31:0] r;
      logic [31:0] e;
      e = exp_read(a);
      do_read(a, r);
      chk(req, r, e);
   endtask

   function automatic logic [7:0] pick_addr(input int k, input bit hi);
      logic [6:0] o;
      case (k)
         0: o = 7'h00; 1: o = 7'h04; 2: o = 7'h08; 3: o = 7'h18;
         4: o = 7'h1C; 5: o = 7'h20; 6: o = 7'h30; 7: o = 7'h0C;
         8: o = 7'h40; default: o = 7'h7C;
      endcase
      pick_addr = {hi, o};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int unused_seed;
      for (int b = 0; b < 2; b++)
         for (int f = 0; f < 6; f++) mreg[b][f] = '0;
      unused_seed = $urandom(32'h5EED_0461);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_pads("R1");
      for (int k = 0; k < 10; k++) begin
         read_chk("R1 read after reset", pick_addr(k, 1'b0));
         read_chk("R1 read after reset", pick_addr(k, 1'b1));
      end

      // R2 set, R3 clear, R4 hold, R5 clear wins
      do_write(8'h04, 32'h0000_0005);
      chk("R2 set drive enable", pad_oe, 32'h0000_0005);
      read_chk("R7 read drive enable", 8'h04);
      do_write(8'h04, 32'h0001_0000);
      chk("R3 clear pin0", pad_oe, 32'h0000_0004);
      do_write(8'h04, 32'h0000_0000);
      chk("R4 empty write holds", pad_oe, 32'h0000_0004);
      do_write(8'h04, 32'h0004_0004);
      chk("R5 clear wins", pad_oe, 32'h0000_0000);

      // R6: high bank
      do_write(8'h84, 32'h0000_8001);
      chk("R6 high bank drive", pad_oe, 32'h8001_0000);
      do_write(8'h98, 32'h0000_00F0);
      chk("R6 high bank pull-up", pad_pu, 32'h00F0_0000);
      check_pads("R6");

      // R7 / R11: each offset, distinct pattern
      do_write(8'h00, 32'h0000_1111);
      do_write(8'h08, 32'h0000_0100);
      do_write(8'h18, 32'h0000_A5A5);
      do_write(8'h1C, 32'h0000_5A00);
      do_write(8'h20, 32'h0000_00FF);
      check_pads("R7");
      for (int k = 0; k < 6; k++) begin
         read_chk("R7 offset map", pick_addr(k, 1'b0));
         read_chk("R7 offset map", pick_addr(k, 1'b1));
      end

      // R9: open-drain on pin 3
      do_write(8'h04, 32'h0000_0008);
      do_write(8'h00, 32'h0000_0008);
      do_write(8'h08, 32'h0000_0008);
      chk("R9 od high releases oe", {31'h0, pad_oe[3]}, 32'h0);
      chk("R9 od out low", {31'h0, pad_out[3]}, 32'h0);
      do_write(8'h00, 32'h0008_0000);
      chk("R9 od low drives", {31'h0, pad_oe[3]}, 32'h1);
      check_pads("R9");

      // R8: read-back with input enable off / on and two-flop latency
      @(negedge clk);
      pad_in = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      do_write(8'hA0, 32'hFFFF_0000);
      read_chk("R8 ie off reads zero", 8'hB0);
      read_chk("R8 masked by ie", 8'h30);
      do_write(8'hA0, 32'h0000_00FF);
      @(negedge clk);
      pad_in = 32'h0000_0000;
      do_read(8'h30, r);
      chk("R8 old level at second edge", r, 32'h0000_00FF);
      do_read(8'h30, r);
      chk("R8 new level at third edge", r, 32'h0000_0000);
      read_chk("R8 high bank", 8'hB0);

      // R10: writes to read-back and unmapped offsets
      do_write(8'h30, 32'h0000_FFFF);
      do_write(8'h0C, 32'h0000_FFFF);
      do_write(8'hC0, 32'hFFFF_FFFF);
      do_write(8'hFC, 32'h0000_FFFF);
      check_pads("R10");
      read_chk("R10 unmapped read", 8'h0C);
      read_chk("R10 unmapped read", 8'hC0);
      read_chk("R10 unmapped read", 8'h7C);

      // Random phase
      for (int i = 0; i < 400; i++) begin
         int op = int'($urandom_range(0, 9));
         logic [7:0] a = pick_addr(int'($urandom_range(0, 9)), 1'($urandom_range(0, 1)));
         if (op < 6) begin
            do_write(a, $urandom());
            check_pads("R2 R3 R5 random");
         end else if (op < 9) begin
            read_chk("R7 R8 random read", a);
         end else begin
            @(negedge clk);
            pad_in = $urandom();
            repeat (3) @(negedge clk);
            read_chk("R8 random read-back", pick_addr(6, 1'($urandom_range(0, 1))));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule